// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block pairs a Hamming encoder with a Hamming decoder, both purely combinational. The code size is fixed by one parameter, the number of check bits. The encoder takes a data word and returns a protected codeword with the check bits interleaved into it. The decoder takes a codeword that may have been corrupted and returns three things: the corrected data word, the raw syndrome, and a flag that reports whether a bit was inverted.

Codeword positions are numbered from 1 upward. Bit `p-1` of the codeword vector holds position `p`. Every position that is a power of two holds a check bit. Because of this layout, the syndrome reads out directly as the number of the faulty position. The minimum distance between legal codewords is three, so any single flipped bit is repaired. Plain parity has distance two and could only detect such an error. The two halves work independently and can sit on opposite sides of a storage element or link.

Top module: `ham_sec_codec`

## Requirements
- R1: With check-bit count `CHK_BITS` = c, the codeword is 2^c-1 bits wide and carries 2^c-c-1 data bits. The default c=4 gives a 15-bit codeword and 11 data bits, with position 15 at vector bit 14.
- R2: Data bits fill the positions that are not powers of two, in ascending order. Data bit 0 sits at position 3, data bit 1 at position 5, and data bit 10 at position 15.
- R3: The check bit at position 2^j makes the parity even across every position whose index has bit j set. For example, data 11'h001 encodes to 15'h0007, and data 11'h7FF encodes to 15'h7FFF.
- R4: The decoder syndrome is the XOR of the indices of all positions that hold a 1. Any legal codeword gives syndrome 0.
- R5: When one data position is flipped, the syndrome equals that position's index, the error flag is 1, and the data output equals the original data.
- R6: When one check-bit position (1, 2, 4, 8 for c=4) is flipped, the syndrome equals that index and the error flag is 1. The data output still equals the original data.
- R7: For a legal codeword the error flag is 0 and the data output equals the data bits read directly from the codeword. An all-zero codeword decodes to all-zero data with syndrome 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data | input | 2^c-c-1 | Data word to encode |
| enc_word | output | 2^c-1 | Encoded codeword, position p at bit p-1 |
| dec_word | input | 2^c-1 | Received codeword, possibly with one flipped bit |
| dec_data | output | 2^c-c-1 | Corrected data word |
| dec_syndrome | output | c | Index of the faulty position, 0 when clean |
| dec_err | output | 1 | High when a bit was inverted |

## Verification
The checker continuously recomputes the parity of each encoder output, so even parity and data placement are checked whenever the inputs change. The same checker confirms that the decoder passes data through untouched when the flag is low or when the syndrome points at a check bit, and that correction never changes more than one data bit. Two properties need a known relation between what was encoded and what was received, so only the bench scenarios can show them: that the syndrome names exactly the position that was flipped, and that correction restores the original word. For that reason the bench encodes random words and injects each single-bit error in turn.

// File: rtl/ham_pkg.sv
package ham_pkg;

   // True when q is a power of two (a check-bit position).
   function automatic bit is_pow2(int unsigned q);
      return (q != 0) && ((q & (q - 1)) == 0);
   endfunction

   // Codeword position (1-based) of data bit k.
   function automatic int unsigned data_pos(int unsigned k);
      int unsigned n;
      int unsigned res;
      n   = 0;
      res = 0;
      for (int unsigned q = 3; q < 512; q++) begin
         if (!is_pow2(q)) begin
            if (n == k && res == 0) res = q;
            n++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/ham_encoder.sv
module ham_encoder #(
   parameter int CHK    = 4,
   localparam int CW_LEN = (1 << CHK) - 1,
   localparam int D_LEN  = CW_LEN - CHK
) (
   input  logic [D_LEN-1:0]  data_i,
   output logic [CW_LEN-1:0] word_o
);

   // Scatter data bits into non-power-of-two positions.
   for (genvar k = 0; k < D_LEN; k++) begin : g_place
      localparam int POS = int'(ham_pkg::data_pos(k));
      assign word_o[POS-1] = data_i[k];
   end

   // One parity bit per power-of-two position.
   for (genvar j = 0; j < CHK; j++) begin : g_check
      logic par;
      always_comb begin
         par = 1'b0;
         for (int k = 0; k < D_LEN; k++) begin
            if (((ham_pkg::data_pos(k) >> j) & 1) != 0) par ^= data_i[k];
         end
      end
      assign word_o[(1 << j) - 1] = par;
   end

endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome #(
   parameter int CHK    = 4,
   localparam int CW_LEN = (1 << CHK) - 1
) (
   input  logic [CW_LEN-1:0] word_i,
   output logic [CHK-1:0]    syn_o
);

   for (genvar j = 0; j < CHK; j++) begin : g_bit
      always_comb begin
         syn_o[j] = 1'b0;
         for (int p = 1; p <= CW_LEN; p++) begin
            if (((p >> j) & 1) != 0) syn_o[j] ^= word_i[p-1];
         end
      end
   end

endmodule

// File: rtl/ham_corrector.sv
module ham_corrector #(
   parameter int CHK    = 4,
   localparam int CW_LEN = (1 << CHK) - 1,
   localparam int D_LEN  = CW_LEN - CHK
) (
   input  logic [CW_LEN-1:0] word_i,
   input  logic [CHK-1:0]    syn_i,
   output logic [D_LEN-1:0]  data_o,
   output logic              err_o
);

   logic [CW_LEN-1:0] fixed;

   // Invert the single position the syndrome names.
   for (genvar p = 1; p <= CW_LEN; p++) begin : g_fix
      localparam logic [CHK-1:0] IDX = CHK'(p);
      assign fixed[p-1] = word_i[p-1] ^ (syn_i == IDX);
   end

   for (genvar k = 0; k < D_LEN; k++) begin : g_pick
      localparam int POS = int'(ham_pkg::data_pos(k));
      assign data_o[k] = fixed[POS-1];
   end

   assign err_o = |syn_i;

endmodule

// File: rtl/ham_sec_codec.sv
module ham_sec_codec #(
   parameter int CHK_BITS = 4,
   localparam int CW_LEN  = (1 << CHK_BITS) - 1,
   localparam int D_LEN   = CW_LEN - CHK_BITS
) (
   input  logic [D_LEN-1:0]    enc_data,
   output logic [CW_LEN-1:0]   enc_word,
   input  logic [CW_LEN-1:0]   dec_word,
   output logic [D_LEN-1:0]    dec_data,
   output logic [CHK_BITS-1:0] dec_syndrome,
   output logic                dec_err
);

   if (CHK_BITS < 2 || CHK_BITS > 8) begin : g_bad_param
      $error("ham_sec_codec: CHK_BITS must lie in 2..8");
   end

   ham_encoder #(.CHK(CHK_BITS)) u_enc (
      .data_i (enc_data),
      .word_o (enc_word)
   );

   ham_syndrome #(.CHK(CHK_BITS)) u_syn (
      .word_i (dec_word),
      .syn_o  (dec_syndrome)
   );

   ham_corrector #(.CHK(CHK_BITS)) u_cor (
      .word_i (dec_word),
      .syn_i  (dec_syndrome),
      .data_o (dec_data),
      .err_o  (dec_err)
   );

endmodule

// File: rtl/ham_codec_chk.sv
module ham_codec_chk #(
   parameter int CHK    = 4,
   localparam int CW_LEN = (1 << CHK) - 1,
   localparam int D_LEN  = CW_LEN - CHK
) (
   input logic [D_LEN-1:0]  enc_data,
   input logic [CW_LEN-1:0] enc_word,
   input logic [CW_LEN-1:0] dec_word,
   input logic [D_LEN-1:0]  dec_data,
   input logic [CHK-1:0]    dec_syndrome,
   input logic              dec_err
);

   logic [CHK-1:0]   enc_par;
   logic [D_LEN-1:0] enc_pay;
   logic [D_LEN-1:0] raw_data;

   always_comb begin
      enc_par = '0;
      for (int p = 1; p <= CW_LEN; p++) begin
         if (enc_word[p-1]) enc_par ^= CHK'(p);
      end
      for (int k = 0; k < D_LEN; k++) begin
         enc_pay[k]  = enc_word[ham_pkg::data_pos(k) - 1];
         raw_data[k] = dec_word[ham_pkg::data_pos(k) - 1];
      end
   end

   always_comb begin
      // R3: every encoded word has even parity in each index group
      p_enc_even_r3: assert (enc_par == '0);
      // R2: data bits appear unchanged at their positions
      p_enc_place_r2: assert (enc_pay == enc_data);
      // R7: clean word passes data through
      p_clean_pass_r7: assert (dec_err || (dec_data == raw_data));
      // R6: a check-position syndrome leaves data untouched
      p_chk_keep_r6: assert (!(dec_err && $onehot(dec_syndrome)) || (dec_data == raw_data));
      // R5: correction alters at most one data bit
      p_one_fix_r5: assert ($countones(dec_data ^ raw_data) <= 1);
   end

endmodule

bind ham_sec_codec ham_codec_chk #(.CHK(CHK_BITS)) u_chk (
   .enc_data     (enc_data),
   .enc_word     (enc_word),
   .dec_word     (dec_word),
   .dec_data     (dec_data),
   .dec_syndrome (dec_syndrome),
   .dec_err      (dec_err)
);

// File: tb/tb_ham_sec_codec.sv
module tb_ham_sec_codec;

   localparam int C  = 4;
   localparam int CW = (1 << C) - 1;
   localparam int DL = CW - C;

   localparam int NVEC = 5;
   localparam logic [DL-1:0] VEC_D [NVEC] = '{11'h000, 11'h001, 11'h002, 11'h400, 11'h7FF};
   localparam logic [CW-1:0] VEC_W [NVEC] = '{15'h0000, 15'h0007, 15'h0019, 15'h408B, 15'h7FFF};

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [DL-1:0] enc_data = '0;
   logic [CW-1:0] enc_word;
   logic [CW-1:0] dec_word = '0;
   logic [DL-1:0] dec_data;
   logic [C-1:0]  dec_syndrome;
   logic          dec_err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   ham_sec_codec #(.CHK_BITS(C)) dut (
      .enc_data     (enc_data),
      .enc_word     (enc_word),
      .dec_word     (dec_word),
      .dec_data     (dec_data),
      .dec_syndrome (dec_syndrome),
      .dec_err      (dec_err)
   );

   // Reference encoder built from R2 and R3.
   function automatic logic [CW-1:0] model_enc(logic [DL-1:0] d);
      logic [CW-1:0] w;
      int n;
      w = '0;
      n = 0;
      for (int p = 1; p <= CW; p++) begin
         if ((p & (p - 1)) != 0) begin
            w[p-1] = d[n];
            n++;
         end
      end
      for (int j = 0; j < C; j++) begin
         logic par;
         par = 1'b0;
         for (int p = 1; p <= CW; p++)
            if ((p & (p - 1)) != 0 && ((p >> j) & 1) != 0) par ^= w[p-1];
         w[(1 << j) - 1] = par;
      end
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [DL-1:0] d, input logic [CW-1:0] w);
      @(negedge clk);
      enc_data = d;
      dec_word = w;
      #1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // Reset state: zero inputs give zero outputs (R7)
      repeat (3) @(negedge clk);
      #1;
      check(enc_word == '0, "R7 zero encode", 32'(enc_word), 0);
      check(dec_data == '0 && dec_syndrome == '0 && !dec_err, "R7 zero decode",
            {dec_data, dec_syndrome, dec_err}, 0);
      rst = 1'b0;

      // Table of known vectors (R1, R2, R3, R4)
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC_D[i], VEC_W[i]);
         check(enc_word == VEC_W[i], "R3 table encode", 32'(enc_word), 32'(VEC_W[i]));
         check(enc_word == model_enc(VEC_D[i]), "R2 table placement", 32'(enc_word),
               32'(model_enc(VEC_D[i])));
         check(dec_syndrome == '0 && !dec_err, "R4 table syndrome",
               {dec_syndrome, dec_err}, 0);
         check(dec_data == VEC_D[i], "R7 table decode", 32'(dec_data), 32'(VEC_D[i]));
      end

      // R1: top data bit lands in vector bit 14 (position 15)
      apply(11'h400, 15'h4000);
      check(enc_word[14] == 1'b1, "R1 top position", 32'(enc_word), 32'h408B);
      check(dec_syndrome == 4'd15 && dec_err, "R1 syndrome of position 15",
            32'(dec_syndrome), 15);

      // Random words with every single-bit error injected
      for (int r = 0; r < 200; r++) begin
         logic [DL-1:0] d;
         logic [CW-1:0] w;
         d = DL'($urandom);
         w = model_enc(d);
         for (int e = 0; e <= CW; e++) begin
            logic [CW-1:0] rx;
            rx = (e == 0) ? w : (w ^ (CW'(1) << (e - 1)));
            apply(d, rx);
            if (e == 0) begin
               check(enc_word == w, "R3 random encode", 32'(enc_word), 32'(w));
               check(dec_syndrome == '0, "R4 clean syndrome", 32'(dec_syndrome), 0);
               check(!dec_err, "R7 clean flag", 32'(dec_err), 0);
               check(dec_data == d, "R7 clean data", 32'(dec_data), 32'(d));
            end else if ((e & (e - 1)) == 0) begin
               check(dec_syndrome == C'(e), "R6 check-bit syndrome", 32'(dec_syndrome), 32'(e));
               check(dec_err, "R6 check-bit flag", 32'(dec_err), 1);
               check(dec_data == d, "R6 check-bit data", 32'(dec_data), 32'(d));
            end else begin
               check(dec_syndrome == C'(e), "R5 data syndrome", 32'(dec_syndrome), 32'(e));
               check(dec_err, "R5 data flag", 32'(dec_err), 1);
               check(dec_data == d, "R5 data corrected", 32'(dec_data), 32'(d));
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule